// File: doc/BRIEF.md
# Indirect Address Generation Unit

This unit turns a memory-access request into a data-memory address. It holds three 16-bit pointers and a 16-bit stack pointer. Each pointer is made of two 8-bit general registers that are written through a register write port, and it can have an 8-bit extension byte placed above it to reach a 24-bit data space. A request names an addressing mode and a pointer. The unit returns the effective address and, for modes that change a pointer, the new pointer value that is written back.

The modes are plain indirect, post-increment, pre-decrement, displacement with a 6-bit unsigned offset, direct 16-bit addressing, stack push and stack pop. Each request occupies the unit for the cycle count of an instruction of that kind. The memory array and instruction decode are not part of this unit.

Top module: `indirect_agu`

## Requirements
- R1: After reset all pointers, extension bytes and the stack pointer are zero, and `busy_o` and `done_o` are low. Register index 26 is the low byte of pointer X and 27 its high byte; 28/29 form Y and 30/31 form Z (selector values X=0, Y=1, Z=2). A register write to any other index changes no pointer.
- R2: Plain mode (op 0) uses the selected pointer as the address and leaves the pointer unchanged (`wb_o` low).
- R3: Post-increment mode (op 1) uses the current pointer as the address, then writes back the pointer plus one.
- R4: Pre-decrement mode (op 2) subtracts one from the pointer, uses the result as the address and writes it back.
- R5: Displacement mode (op 3) adds `disp_i`, zero-extended, to Y or Z and leaves the pointer unchanged. With X selected it raises an error and changes nothing.
- R6: With `ext_en_i` high the address is {extension byte, pointer}, and an increment or decrement carries or borrows into the extension byte. With it low the upper address byte is zero, the pointer wraps within 16 bits, and the extension byte is left unchanged.
- R7: Direct mode (op 4) outputs `direct_i` as the address with a zero upper byte, whatever `ext_en_i` is.
- R8: A request is accepted only while `busy_o` is low. Direct mode takes 3 cycles and every other mode takes 2. The accept cycle counts as the first, and `done_o` is high in the last. Requests made while busy are ignored.
- R9: Push (op 5) addresses the current stack pointer and then decrements it. Pop (op 6) increments the stack pointer and then addresses the new value. Both report the new stack pointer on `wb_val_o` with `wb_o` high.
- R10: An error (displacement on X, selector 3 on a pointer mode, or op 7) raises `err_o` with `done_o`. It keeps `addr_valid_o` and `wb_o` low and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | General register write strobe |
| reg_idx_i | input | 5 | General register index |
| reg_wdata_i | input | 8 | General register write data |
| ext_we_i | input | 1 | Extension byte write strobe |
| ext_sel_i | input | 2 | Pointer whose extension byte is written |
| ext_wdata_i | input | 8 | Extension byte write data |
| sp_we_i | input | 1 | Stack pointer load strobe |
| sp_wdata_i | input | 16 | Stack pointer load value |
| ext_en_i | input | 1 | Use the extension byte above pointers |
| req_i | input | 1 | Access request |
| op_i | input | 3 | Addressing mode |
| sel_i | input | 2 | Pointer select |
| disp_i | input | 6 | Unsigned displacement |
| direct_i | input | 16 | Direct address |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | Last cycle of a request |
| addr_valid_o | output | 1 | Address valid, with done_o |
| addr_o | output | 24 | Effective address |
| wb_o | output | 1 | Write-back valid, with done_o |
| wb_val_o | output | 24 | Updated pointer or stack pointer |
| err_o | output | 1 | Illegal request, with done_o |

## Verification
The assertions assume that `ext_en_i` stays constant from a request's acceptance until its `done_o` cycle. They also assume that no register, extension or stack-pointer write lands in the same cycle as an accepted request that updates the same pointer. The stimulus changes `ext_en_i` only between requests and issues loads before a request or after it has finished. Only the busy-window test drives `req_i` during an operation, so that the ignore rule is checked.

// File: rtl/agu_pkg.sv
package agu_pkg;
  typedef enum logic [2:0] {
    AGU_PLAIN   = 3'd0,
    AGU_POSTINC = 3'd1,
    AGU_PREDEC  = 3'd2,
    AGU_DISP    = 3'd3,
    AGU_DIRECT  = 3'd4,
    AGU_PUSH    = 3'd5,
    AGU_POP     = 3'd6,
    AGU_RSVD    = 3'd7
  } agu_op_e;

  localparam int SEL_X = 0;

  function automatic logic [1:0] op_cycles(agu_op_e op);
    return (op == AGU_DIRECT) ? 2'd3 : 2'd2;
  endfunction
endpackage

// File: rtl/agu_ptr_file.sv
module agu_ptr_file #(
  parameter int DATA_W   = 8,
  parameter int EXT_W    = 8,
  parameter int NPTR     = 3,
  parameter int REG_BASE = 26,
  parameter int IDX_W    = 5,
  parameter int SEL_W    = 2,
  localparam int PTR_W   = 2 * DATA_W,
  localparam int ADDR_W  = PTR_W + EXT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [IDX_W-1:0]  reg_idx_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  input  logic              ext_we_i,
  input  logic [SEL_W-1:0]  ext_sel_i,
  input  logic [EXT_W-1:0]  ext_wdata_i,
  input  logic              sp_we_i,
  input  logic [PTR_W-1:0]  sp_wdata_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic              upd_ptr_i,
  input  logic              upd_ext_i,
  input  logic [ADDR_W-1:0] upd_val_i,
  input  logic              upd_sp_i,
  input  logic [PTR_W-1:0]  upd_sp_val_i,
  output logic [PTR_W-1:0]  ptr_o,
  output logic [EXT_W-1:0]  ext_o,
  output logic [PTR_W-1:0]  sp_o
);
  logic [NPTR-1:0][PTR_W-1:0] ptr_all;
  logic [NPTR-1:0][EXT_W-1:0] ext_all;
  logic [PTR_W-1:0]           sp_q;

  for (genvar p = 0; p < NPTR; p++) begin : g_ptr
    localparam int LO_IDX = REG_BASE + 2 * p;
    localparam int HI_IDX = LO_IDX + 1;
    logic [DATA_W-1:0] lo_q, hi_q;
    logic [EXT_W-1:0]  ext_q;
    logic              hit;
    assign hit = upd_ptr_i && (sel_i == SEL_W'(p));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        lo_q  <= '0;
        hi_q  <= '0;
        ext_q <= '0;
      end else if (hit) begin
        // access update wins over same-cycle loads
        lo_q <= upd_val_i[DATA_W-1:0];
        hi_q <= upd_val_i[PTR_W-1:DATA_W];
        if (upd_ext_i) ext_q <= upd_val_i[ADDR_W-1:PTR_W];
      end else begin
        if (reg_we_i && reg_idx_i == IDX_W'(LO_IDX)) lo_q <= reg_wdata_i;
        if (reg_we_i && reg_idx_i == IDX_W'(HI_IDX)) hi_q <= reg_wdata_i;
        if (ext_we_i && ext_sel_i == SEL_W'(p))      ext_q <= ext_wdata_i;
      end
    end

    assign ptr_all[p] = {hi_q, lo_q};
    assign ext_all[p] = ext_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sp_q <= '0;
    else if (upd_sp_i) sp_q <= upd_sp_val_i;
    else if (sp_we_i)  sp_q <= sp_wdata_i;
  end

  always_comb begin
    ptr_o = '0;
    ext_o = '0;
    for (int p = 0; p < NPTR; p++) begin
      if (sel_i == SEL_W'(p)) begin
        ptr_o = ptr_all[p];
        ext_o = ext_all[p];
      end
    end
  end

  assign sp_o = sp_q;
endmodule

// File: rtl/agu_addr_calc.sv
module agu_addr_calc
  import agu_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int EXT_W   = 8,
  parameter int DISP_W  = 6,
  parameter int NPTR    = 3,
  parameter int SEL_W   = 2,
  localparam int PTR_W  = 2 * DATA_W,
  localparam int ADDR_W = PTR_W + EXT_W
) (
  input  agu_op_e           op_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [PTR_W-1:0]  ptr_i,
  input  logic [EXT_W-1:0]  ext_i,
  input  logic              ext_en_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic [PTR_W-1:0]  direct_i,
  input  logic [PTR_W-1:0]  sp_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [ADDR_W-1:0] wb_val_o,
  output logic              upd_ptr_o,
  output logic              upd_sp_o,
  output logic [PTR_W-1:0]  sp_new_o,
  output logic              err_o
);
  logic [ADDR_W-1:0] mask, cur, inc, dec, dsp;
  logic              sel_ok;

  assign mask   = ext_en_i ? '1 : {{EXT_W{1'b0}}, {PTR_W{1'b1}}};
  assign cur    = {ext_i, ptr_i} & mask;
  assign inc    = (cur + ADDR_W'(1)) & mask;
  assign dec    = (cur - ADDR_W'(1)) & mask;
  assign dsp    = (cur + ADDR_W'(disp_i)) & mask;
  assign sel_ok = int'(sel_i) < NPTR;

  always_comb begin
    addr_o    = cur;
    wb_val_o  = '0;
    upd_ptr_o = 1'b0;
    upd_sp_o  = 1'b0;
    sp_new_o  = sp_i;
    err_o     = !sel_ok;
    unique case (op_i)
      AGU_PLAIN: ;
      AGU_POSTINC: begin
        wb_val_o  = inc;
        upd_ptr_o = sel_ok;
      end
      AGU_PREDEC: begin
        addr_o    = dec;
        wb_val_o  = dec;
        upd_ptr_o = sel_ok;
      end
      AGU_DISP: begin
        addr_o = dsp;
        err_o  = !sel_ok || (int'(sel_i) == SEL_X);
      end
      AGU_DIRECT: begin
        addr_o = {{EXT_W{1'b0}}, direct_i};
        err_o  = 1'b0;
      end
      AGU_PUSH: begin
        addr_o   = {{EXT_W{1'b0}}, sp_i};
        sp_new_o = sp_i - PTR_W'(1);
        wb_val_o = {{EXT_W{1'b0}}, sp_new_o};
        upd_sp_o = 1'b1;
        err_o    = 1'b0;
      end
      AGU_POP: begin
        sp_new_o = sp_i + PTR_W'(1);
        addr_o   = {{EXT_W{1'b0}}, sp_new_o};
        wb_val_o = addr_o;
        upd_sp_o = 1'b1;
        err_o    = 1'b0;
      end
      default: err_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/agu_seq.sv
module agu_seq
  import agu_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  agu_op_e           op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] wb_val_i,
  input  logic              wb_i,
  input  logic              err_i,
  output logic              accept_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              addr_valid_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              wb_o,
  output logic [ADDR_W-1:0] wb_val_o,
  output logic              err_o
);
  logic [1:0]        cnt_q;
  logic [ADDR_W-1:0] addr_q, wb_val_q;
  logic              wb_q, err_q;

  assign accept_o = req_i && (cnt_q == 2'd0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      addr_q   <= '0;
      wb_val_q <= '0;
      wb_q     <= 1'b0;
      err_q    <= 1'b0;
    end else if (accept_o) begin
      cnt_q    <= op_cycles(op_i) - 2'd1;
      addr_q   <= addr_i;
      wb_val_q <= wb_val_i;
      wb_q     <= wb_i && !err_i;
      err_q    <= err_i;
    end else if (cnt_q != 2'd0) begin
      cnt_q <= cnt_q - 2'd1;
    end
  end

  assign busy_o       = cnt_q != 2'd0;
  assign done_o       = cnt_q == 2'd1;
  assign addr_valid_o = done_o && !err_q;
  assign wb_o         = done_o && wb_q;
  assign err_o        = done_o && err_q;
  assign addr_o       = addr_q;
  assign wb_val_o     = wb_val_q;
endmodule

// File: rtl/indirect_agu.sv
module indirect_agu
  import agu_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int EXT_W    = 8,
  parameter int DISP_W   = 6,
  parameter int NPTR     = 3,
  parameter int REG_BASE = 26,
  parameter int IDX_W    = 5,
  parameter int SEL_W    = 2,
  localparam int PTR_W   = 2 * DATA_W,
  localparam int ADDR_W  = PTR_W + EXT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [IDX_W-1:0]  reg_idx_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  input  logic              ext_we_i,
  input  logic [SEL_W-1:0]  ext_sel_i,
  input  logic [EXT_W-1:0]  ext_wdata_i,
  input  logic              sp_we_i,
  input  logic [PTR_W-1:0]  sp_wdata_i,
  input  logic              ext_en_i,
  input  logic              req_i,
  input  logic [2:0]        op_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic [PTR_W-1:0]  direct_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              addr_valid_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              wb_o,
  output logic [ADDR_W-1:0] wb_val_o,
  output logic              err_o
);
  agu_op_e           op;
  logic [PTR_W-1:0]  ptr_cur, sp_cur, sp_new;
  logic [EXT_W-1:0]  ext_cur;
  logic [ADDR_W-1:0] calc_addr, calc_wb;
  logic              calc_upd_ptr, calc_upd_sp, calc_err, accept;

  assign op = agu_op_e'(op_i);

  agu_ptr_file #(
    .DATA_W(DATA_W), .EXT_W(EXT_W), .NPTR(NPTR),
    .REG_BASE(REG_BASE), .IDX_W(IDX_W), .SEL_W(SEL_W)
  ) u_file (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reg_we_i    (reg_we_i),
    .reg_idx_i   (reg_idx_i),
    .reg_wdata_i (reg_wdata_i),
    .ext_we_i    (ext_we_i),
    .ext_sel_i   (ext_sel_i),
    .ext_wdata_i (ext_wdata_i),
    .sp_we_i     (sp_we_i),
    .sp_wdata_i  (sp_wdata_i),
    .sel_i       (sel_i),
    .upd_ptr_i   (accept && calc_upd_ptr),
    .upd_ext_i   (ext_en_i),
    .upd_val_i   (calc_wb),
    .upd_sp_i    (accept && calc_upd_sp),
    .upd_sp_val_i(sp_new),
    .ptr_o       (ptr_cur),
    .ext_o       (ext_cur),
    .sp_o        (sp_cur)
  );

  agu_addr_calc #(
    .DATA_W(DATA_W), .EXT_W(EXT_W), .DISP_W(DISP_W),
    .NPTR(NPTR), .SEL_W(SEL_W)
  ) u_calc (
    .op_i     (op),
    .sel_i    (sel_i),
    .ptr_i    (ptr_cur),
    .ext_i    (ext_cur),
    .ext_en_i (ext_en_i),
    .disp_i   (disp_i),
    .direct_i (direct_i),
    .sp_i     (sp_cur),
    .addr_o   (calc_addr),
    .wb_val_o (calc_wb),
    .upd_ptr_o(calc_upd_ptr),
    .upd_sp_o (calc_upd_sp),
    .sp_new_o (sp_new),
    .err_o    (calc_err)
  );

  agu_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req_i),
    .op_i        (op),
    .addr_i      (calc_addr),
    .wb_val_i    (calc_wb),
    .wb_i        (calc_upd_ptr || calc_upd_sp),
    .err_i       (calc_err),
    .accept_o    (accept),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .addr_valid_o(addr_valid_o),
    .addr_o      (addr_o),
    .wb_o        (wb_o),
    .wb_val_o    (wb_val_o),
    .err_o       (err_o)
  );
endmodule

// File: rtl/indirect_agu_chk.sv
module indirect_agu_chk #(
  parameter int PTR_W  = 16,
  parameter int ADDR_W = 24,
  parameter int SEL_W  = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic [2:0]        op_i,
  input logic [SEL_W-1:0]  sel_i,
  input logic              ext_en_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              addr_valid_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic              wb_o,
  input logic              err_o
);
  logic acc;
  assign acc = req_i && !busy_o;

  a_r8_two_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && op_i != 3'd4 |=> done_o);

  a_r8_three_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && op_i == 3'd4 |=> !done_o ##1 done_o);

  a_r8_idle_after_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);

  a_r5_x_disp_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && op_i == 3'd3 && sel_i == '0 |=> err_o && !addr_valid_o);

  a_r10_err_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !wb_o && !addr_valid_o);

  a_r6_ext_off_upper: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_valid_o && !ext_en_i |-> addr_o[ADDR_W-1:PTR_W] == '0);

  a_r10_done_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_valid_o || wb_o || err_o) |-> done_o);
endmodule

bind indirect_agu indirect_agu_chk #(
  .PTR_W(PTR_W), .ADDR_W(ADDR_W), .SEL_W(SEL_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .op_i        (op_i),
  .sel_i       (sel_i),
  .ext_en_i    (ext_en_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .addr_valid_o(addr_valid_o),
  .addr_o      (addr_o),
  .wb_o        (wb_o),
  .err_o       (err_o)
);

// File: tb/indirect_agu_tb.sv
module indirect_agu_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 0, ext_we_i = 0, sp_we_i = 0, ext_en_i = 0, req_i = 0;
  logic [4:0]  reg_idx_i = '0;
  logic [7:0]  reg_wdata_i = '0, ext_wdata_i = '0;
  logic [1:0]  ext_sel_i = '0, sel_i = '0;
  logic [15:0] sp_wdata_i = '0, direct_i = '0;
  logic [2:0]  op_i = '0;
  logic [5:0]  disp_i = '0;
  logic        busy_o, done_o, addr_valid_o, wb_o, err_o;
  logic [23:0] addr_o, wb_val_o;

  int checks = 0, errors = 0;
  bit finished = 0;

  logic [23:0] r_addr, r_wbv;
  logic        r_av, r_wb, r_err;
  int          r_cyc;

  always #4ns clk = ~clk;

  indirect_agu u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .reg_we_i(reg_we_i), .reg_idx_i(reg_idx_i), .reg_wdata_i(reg_wdata_i),
    .ext_we_i(ext_we_i), .ext_sel_i(ext_sel_i), .ext_wdata_i(ext_wdata_i),
    .sp_we_i(sp_we_i), .sp_wdata_i(sp_wdata_i), .ext_en_i(ext_en_i),
    .req_i(req_i), .op_i(op_i), .sel_i(sel_i), .disp_i(disp_i), .direct_i(direct_i),
    .busy_o(busy_o), .done_o(done_o), .addr_valid_o(addr_valid_o), .addr_o(addr_o),
    .wb_o(wb_o), .wb_val_o(wb_val_o), .err_o(err_o)
  );

  typedef struct packed {
    logic [2:0]  op;
    logic [1:0]  sel;
    logic [5:0]  disp;
    logic [15:0] dir;
    logic        ext;
    logic [23:0] addr;
    logic [23:0] wbv;
    logic        wb;
    logic        err;
    logic [1:0]  cyc;
  } vec_t;

  // op: 0 plain 1 postinc 2 predec 3 disp 4 direct 5 push 6 pop; sel X=0 Y=1 Z=2
  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 2'd0, 6'd0,  16'h0,    1'b0, 24'h0010FF, 24'h0,      1'b0, 1'b0, 2'd2}, // R2
    '{3'd1, 2'd0, 6'd0,  16'h0,    1'b0, 24'h0010FF, 24'h001100, 1'b1, 1'b0, 2'd2}, // R3
    '{3'd0, 2'd0, 6'd0,  16'h0,    1'b0, 24'h001100, 24'h0,      1'b0, 1'b0, 2'd2}, // R3
    '{3'd2, 2'd1, 6'd0,  16'h0,    1'b0, 24'h001FFF, 24'h001FFF, 1'b1, 1'b0, 2'd2}, // R4
    '{3'd3, 2'd1, 6'd63, 16'h0,    1'b0, 24'h00203E, 24'h0,      1'b0, 1'b0, 2'd2}, // R5
    '{3'd3, 2'd0, 6'd5,  16'h0,    1'b0, 24'h0,      24'h0,      1'b0, 1'b1, 2'd2}, // R5
    '{3'd0, 2'd0, 6'd0,  16'h0,    1'b0, 24'h001100, 24'h0,      1'b0, 1'b0, 2'd2}, // R5
    '{3'd1, 2'd2, 6'd0,  16'h0,    1'b0, 24'h00FFFF, 24'h000000, 1'b1, 1'b0, 2'd2}, // R6
    '{3'd0, 2'd2, 6'd0,  16'h0,    1'b1, 24'h030000, 24'h0,      1'b0, 1'b0, 2'd2}, // R6
    '{3'd2, 2'd2, 6'd0,  16'h0,    1'b1, 24'h02FFFF, 24'h02FFFF, 1'b1, 1'b0, 2'd2}, // R6
    '{3'd1, 2'd2, 6'd0,  16'h0,    1'b1, 24'h02FFFF, 24'h030000, 1'b1, 1'b0, 2'd2}, // R6
    '{3'd3, 2'd2, 6'd0,  16'h0,    1'b1, 24'h030000, 24'h0,      1'b0, 1'b0, 2'd2}, // R5
    '{3'd3, 2'd1, 6'd1,  16'h0,    1'b1, 24'h022000, 24'h0,      1'b0, 1'b0, 2'd2}, // R5
    '{3'd4, 2'd0, 6'd0,  16'hBEEF, 1'b0, 24'h00BEEF, 24'h0,      1'b0, 1'b0, 2'd3}, // R7
    '{3'd5, 2'd0, 6'd0,  16'h0,    1'b0, 24'h0008FF, 24'h0008FE, 1'b1, 1'b0, 2'd2}, // R9
    '{3'd5, 2'd0, 6'd0,  16'h0,    1'b0, 24'h0008FE, 24'h0008FD, 1'b1, 1'b0, 2'd2}, // R9
    '{3'd6, 2'd0, 6'd0,  16'h0,    1'b0, 24'h0008FE, 24'h0008FE, 1'b1, 1'b0, 2'd2}, // R9
    '{3'd2, 2'd0, 6'd0,  16'h0,    1'b0, 24'h0010FF, 24'h0010FF, 1'b1, 1'b0, 2'd2}, // R4
    '{3'd0, 2'd0, 6'd0,  16'h0,    1'b1, 24'h0110FF, 24'h0,      1'b0, 1'b0, 2'd2}, // R6
    '{3'd4, 2'd0, 6'd0,  16'h0001, 1'b1, 24'h000001, 24'h0,      1'b0, 1'b0, 2'd3}  // R7
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_op(input logic [2:0] op, input logic [1:0] sel, input logic [5:0] disp,
                       input logic [15:0] dir, input logic ext);
    @(negedge clk);
    ext_en_i = ext; op_i = op; sel_i = sel; disp_i = disp; direct_i = dir; req_i = 1'b1;
    @(negedge clk);
    req_i = 1'b0;
    r_cyc = 2;
    while (!done_o && r_cyc < 8) begin
      @(negedge clk);
      r_cyc++;
    end
    r_addr = addr_o; r_av = addr_valid_o; r_wb = wb_o; r_wbv = wb_val_o; r_err = err_o;
  endtask

  task automatic wr_reg(input logic [4:0] idx, input logic [7:0] d);
    @(negedge clk); reg_we_i = 1'b1; reg_idx_i = idx; reg_wdata_i = d;
    @(negedge clk); reg_we_i = 1'b0;
  endtask

  task automatic wr_ext(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk); ext_we_i = 1'b1; ext_sel_i = s; ext_wdata_i = d;
    @(negedge clk); ext_we_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 busy after reset", 32'(busy_o), 32'd0);
    chk("R1 done after reset", 32'(done_o), 32'd0);
    do_op(3'd0, 2'd2, 6'd0, 16'h0, 1'b1);
    chk("R1 Z zero after reset", 32'(r_addr), 32'h0);
    do_op(3'd5, 2'd0, 6'd0, 16'h0, 1'b0);
    chk("R9 push at reset sp addr", 32'(r_addr), 32'h0);
    chk("R9 push wrap wb", 32'(r_wbv), 32'h00FFFF);

    // pointer setup: X=10FF Y=2000 Z=FFFF, ext 01/02/03, SP=08FF
    wr_reg(5'd26, 8'hFF); wr_reg(5'd27, 8'h10);
    wr_reg(5'd28, 8'h00); wr_reg(5'd29, 8'h20);
    wr_reg(5'd30, 8'hFF); wr_reg(5'd31, 8'hFF);
    wr_ext(2'd0, 8'h01); wr_ext(2'd1, 8'h02); wr_ext(2'd2, 8'h03);
    @(negedge clk); sp_we_i = 1'b1; sp_wdata_i = 16'h08FF;
    @(negedge clk); sp_we_i = 1'b0;

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VECS[i];
      do_op(v.op, v.sel, v.disp, v.dir, v.ext);
      chk($sformatf("R8 vec%0d cycles", i), 32'(r_cyc), 32'(v.cyc));
      chk($sformatf("R10 vec%0d err", i), 32'(r_err), 32'(v.err));
      chk($sformatf("R2 vec%0d addr_valid", i), 32'(r_av), 32'(!v.err));
      if (!v.err) chk($sformatf("R2 vec%0d addr", i), 32'(r_addr), 32'(v.addr));
      chk($sformatf("R3 vec%0d wb flag", i), 32'(r_wb), 32'(v.wb));
      if (v.wb) chk($sformatf("R4 vec%0d wb value", i), 32'(r_wbv), 32'(v.wbv));
    end

    // R1: writes to non-pointer indices leave X and Y alone
    wr_reg(5'd25, 8'hAA);
    wr_reg(5'd0, 8'h55);
    do_op(3'd0, 2'd0, 6'd0, 16'h0, 1'b1);
    chk("R1 X untouched by idx 25/0", 32'(r_addr), 32'h0110FF);
    do_op(3'd0, 2'd1, 6'd0, 16'h0, 1'b1);
    chk("R1 Y untouched by idx 25/0", 32'(r_addr), 32'h021FFF);

    // R8: request while busy is dropped
    @(negedge clk);
    ext_en_i = 1'b1; op_i = 3'd4; direct_i = 16'h1234; req_i = 1'b1;
    @(negedge clk);
    chk("R8 busy during direct", 32'(busy_o), 32'd1);
    op_i = 3'd1; sel_i = 2'd0;
    @(negedge clk);
    req_i = 1'b0;
    chk("R8 direct done on third cycle", 32'(done_o), 32'd1);
    chk("R7 direct addr", 32'(addr_o), 32'h001234);
    @(negedge clk);
    chk("R8 no second op started", 32'(busy_o), 32'd0);
    do_op(3'd0, 2'd0, 6'd0, 16'h0, 1'b1);
    chk("R8 X unchanged by dropped postinc", 32'(r_addr), 32'h0110FF);

    // R10: selector 3 and reserved op
    do_op(3'd1, 2'd3, 6'd0, 16'h0, 1'b0);
    chk("R10 sel3 err", 32'(r_err), 32'd1);
    chk("R10 sel3 no wb", 32'(r_wb), 32'd0);
    do_op(3'd7, 2'd0, 6'd0, 16'h0, 1'b0);
    chk("R10 op7 err", 32'(r_err), 32'd1);
    chk("R10 op7 no addr", 32'(r_av), 32'd0);
    do_op(3'd0, 2'd2, 6'd0, 16'h0, 1'b1);
    chk("R10 Z unchanged", 32'(r_addr), 32'h030000);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule